// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit translates a 32-bit effective address through a small set of programmable block mappings. Each mapping is a pair of 32-bit words. The upper word holds the effective tag, a block length and two privilege-valid bits. The lower word holds the real-page base and a two-bit protection code. Instruction fetches and data accesses each have their own set of mappings. A request is strobed with an address, an access kind and a privilege level. One cycle later the unit reports one of three results: a hit, a protection fault, or a miss. On a hit or a fault it also gives the translated address and the read/write/execute rights of the winning mapping.

The block length is a mask. It has two uses. Bits set in the mask drop those effective-address bits from the tag compare. The same bits are then copied from the effective address into the physical address. This lets one mapping cover anything from 128 KiB to 256 MiB. Mappings are loaded through a simple word-wide write port.

Top module: `blk_xlate_match`

## Requirements
- R1: After reset every mapping word is zero, so no mapping is live and every request misses. While in reset and idle, all response outputs are zero.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. In that cycle exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` is high. In every other cycle all response outputs are zero.
- R3: `req_kind` bit 1 set means an instruction fetch, and it searches the instruction set. Otherwise the access is a data access and searches the data set, with bit 0 set meaning a store and clear meaning a load. On the write port, `wr_side`=1 selects the instruction set and 0 selects the data set.
- R4: Upper-word bit 1 makes a mapping live for supervisor requests (`req_user`=0). Upper-word bit 0 makes it live for user requests (`req_user`=1).
- R5: The length mask places upper-word bits 12:2 at address bits 27:17. A mapping matches when effective bits 31:28 equal upper bits 31:28. For bits 27:17, each bit must equal the upper-word bit wherever the mask is 0. Where the mask is 1, the stored upper bit must be 0.
- R6: The physical address is built as follows. Bits 31:28 are lower-word bits 31:28. Bits 27:17 are lower-word bits 27:17 ORed with the effective bits selected by the mask. Bits 16:0 are effective bits 16:0.
- R7: `rsp_perm` is {read, write, execute}. Lower-word bits 1:0 give the rights: 0 grants none, 2 grants all three, and 1 or 3 grant read and execute.
- R8: The lowest-indexed mapping that both matches and is live wins. Mappings that match but are not live for the request's privilege are skipped.
- R9: A load needs read, a store needs write and a fetch needs execute. When the winning mapping denies the access, `rsp_fault` is raised and the mapping's address and rights are still reported.
- R10: On a miss, `rsp_pa` and `rsp_perm` are zero.
- R11: A word written with `wr_en` affects requests from the next cycle on. A request in the same cycle as the write sees the old contents. `wr_hi`=1 writes the upper word and 0 writes the lower word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Mapping word write strobe |
| wr_side | input | 1 | 1 = instruction set, 0 = data set |
| wr_idx | input | 2 | Mapping index |
| wr_hi | input | 1 | 1 = upper word, 0 = lower word |
| wr_data | input | 32 | Word to write |
| req_valid | input | 1 | Request strobe |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access kind: bit1 fetch, bit0 store |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Winning mapping permits the access |
| rsp_miss | output | 1 | No live matching mapping |
| rsp_fault | output | 1 | Winning mapping denies the access |
| rsp_pa | output | 32 | Translated address |
| rsp_perm | output | 3 | Rights {read, write, execute} |

## Verification
Some internal faults show up only as wrong response values. A wrong length-mask position shows as a miss where a hit was due, or as physical bits 27:17 taken from the wrong source. A swapped privilege bit or a wrong winner shows as a wrong `rsp_perm` or `rsp_pa`. Any of these appears in the response cycle of the first request that touches the affected mapping. A write landing in the wrong set or word shows on the first request after the write that uses it. Random mappings are built close to the request addresses, so partial-mask matches and overlapping mappings come up often.

// File: rtl/bxm_pkg.sv
package bxm_pkg;

  localparam logic [31:0] EA_TOP_MSK  = 32'hF000_0000;
  localparam logic [31:0] EA_MID_MSK  = 32'h0FFE_0000;
  localparam logic [31:0] LEN_FLD_MSK = 32'h0000_1FFC;
  localparam int          LEN_SHIFT   = 15;
  localparam logic [31:0] PASS_MSK    = 32'h0001_FFFF;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  function automatic logic [31:0] len_mask(input logic [31:0] upper);
    return (upper & LEN_FLD_MSK) << LEN_SHIFT;
  endfunction

  function automatic logic tag_hit(input logic [31:0] upper, input logic [31:0] ea);
    logic [31:0] m;
    m = len_mask(upper);
    return ((ea & EA_TOP_MSK) == (upper & EA_TOP_MSK)) &&
           (((ea & EA_MID_MSK) & ~m) == (upper & EA_MID_MSK));
  endfunction

  function automatic logic [31:0] phys_addr(input logic [31:0] upper,
                                            input logic [31:0] lower,
                                            input logic [31:0] ea);
    logic [31:0] m;
    m = len_mask(upper);
    return (lower & EA_TOP_MSK) | (ea & EA_MID_MSK & m) |
           (lower & EA_MID_MSK) | (ea & PASS_MSK);
  endfunction

  function automatic perm_t decode_perm(input logic [1:0] code);
    perm_t p;
    case (code)
      2'd0:    p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
      2'd2:    p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
      default: p = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
    endcase
    return p;
  endfunction

  function automatic logic perm_allows(input perm_t p, input logic [1:0] kind);
    if (kind[1])      return p.ex;
    else if (kind[0]) return p.wr;
    else              return p.rd;
  endfunction

endpackage

// File: rtl/bxm_regbank.sv
module bxm_regbank #(
  parameter int N_ENT = 4,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_side,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  wr_hi,
  input  logic [31:0]           wr_data,
  output logic [N_ENT-1:0][31:0] up_i,
  output logic [N_ENT-1:0][31:0] lo_i,
  output logic [N_ENT-1:0][31:0] up_d,
  output logic [N_ENT-1:0][31:0] lo_d
);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        up_i[g] <= '0;
        lo_i[g] <= '0;
        up_d[g] <= '0;
        lo_d[g] <= '0;
      end else if (sel) begin
        if (wr_side && wr_hi)        up_i[g] <= wr_data;
        else if (wr_side)            lo_i[g] <= wr_data;
        else if (wr_hi)              up_d[g] <= wr_data;
        else                         lo_d[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/bxm_entry_eval.sv
module bxm_entry_eval
  import bxm_pkg::*;
(
  input  logic [31:0] upper,
  input  logic [31:0] lower,
  input  logic [31:0] ea,
  input  logic        user,
  output logic        tag_match,
  output logic        live,
  output perm_t       perm,
  output logic [31:0] pa
);

  always_comb begin
    tag_match = tag_hit(upper, ea);
    live      = user ? upper[0] : upper[1];
    perm      = live ? decode_perm(lower[1:0]) : perm_t'(3'b000);
    pa        = phys_addr(upper, lower, ea);
  end

endmodule

// File: rtl/bxm_prio_pick.sv
module bxm_prio_pick
  import bxm_pkg::*;
#(
  parameter int N_ENT = 4
) (
  input  logic [N_ENT-1:0]       cand,
  input  logic [N_ENT-1:0][31:0] pa_arr,
  input  perm_t [N_ENT-1:0]      perm_arr,
  output logic                   found,
  output logic [31:0]            pa,
  output perm_t                  perm
);

  always_comb begin
    found = 1'b0;
    pa    = '0;
    perm  = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (cand[k]) begin
        found = 1'b1;
        pa    = pa_arr[k];
        perm  = perm_arr[k];
      end
    end
  end

endmodule

// File: rtl/blk_xlate_match.sv
module blk_xlate_match
  import bxm_pkg::*;
#(
  parameter int N_ENT = 4,
  parameter int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_side,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_hi,
  input  logic [31:0]      wr_data,
  input  logic             req_valid,
  input  logic [31:0]      req_ea,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [31:0]      rsp_pa,
  output logic [2:0]       rsp_perm
);

  logic [N_ENT-1:0][31:0] up_i, lo_i, up_d, lo_d, up_sel, lo_sel;
  logic [N_ENT-1:0][31:0] pa_arr;
  perm_t [N_ENT-1:0]      perm_arr;
  logic [N_ENT-1:0]       tag_vec, live_vec, cand_vec;
  logic                   is_fetch, found, granted;
  logic [31:0]            pick_pa;
  perm_t                  pick_perm;

  bxm_regbank #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side),
    .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_data(wr_data),
    .up_i(up_i), .lo_i(lo_i), .up_d(up_d), .lo_d(lo_d)
  );

  assign is_fetch = req_kind[1];
  assign up_sel   = is_fetch ? up_i : up_d;
  assign lo_sel   = is_fetch ? lo_i : lo_d;

  for (genvar g = 0; g < N_ENT; g++) begin : g_eval
    bxm_entry_eval u_eval (
      .upper(up_sel[g]), .lower(lo_sel[g]), .ea(req_ea), .user(req_user),
      .tag_match(tag_vec[g]), .live(live_vec[g]),
      .perm(perm_arr[g]), .pa(pa_arr[g])
    );
  end

  assign cand_vec = tag_vec & live_vec;

  bxm_prio_pick #(.N_ENT(N_ENT)) u_pick (
    .cand(cand_vec), .pa_arr(pa_arr), .perm_arr(perm_arr),
    .found(found), .pa(pick_pa), .perm(pick_perm)
  );

  assign granted = perm_allows(pick_perm, req_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && found && granted;
      rsp_fault <= req_valid && found && !granted;
      rsp_miss  <= req_valid && !found;
      rsp_pa    <= (req_valid && found) ? pick_pa : '0;
      rsp_perm  <= (req_valid && found) ? 3'(pick_perm) : 3'b000;
    end
  end

endmodule

// File: rtl/bxm_checker.sv
module bxm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_ea,
  input logic [1:0]  req_kind,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_miss,
  input logic        rsp_fault,
  input logic [31:0] rsp_pa,
  input logic [2:0]  rsp_perm
);

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_miss, rsp_fault}) &&
    (rsp_valid == (rsp_hit || rsp_miss || rsp_fault)));

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pa == 32'h0 && rsp_perm == 3'b000));

  // R9
  hit_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit |-> (($past(req_kind[1]) && rsp_perm[0]) ||
                                (!$past(req_kind[1]) && $past(req_kind[0]) && rsp_perm[1]) ||
                                (!$past(req_kind[1]) && !$past(req_kind[0]) && rsp_perm[2]))));

  // R9
  fault_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_fault |-> (($past(req_kind[1]) && !rsp_perm[0]) ||
                                  (!$past(req_kind[1]) && $past(req_kind[0]) && !rsp_perm[1]) ||
                                  (!$past(req_kind[1]) && !$past(req_kind[0]) && !rsp_perm[2]))));

  // R6
  low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((rsp_hit || rsp_fault) |-> (rsp_pa[16:0] == $past(req_ea[16:0]))));

endmodule

bind blk_xlate_match bxm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
  .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
  .rsp_perm(rsp_perm)
);

// File: tb/sim_blk_xlate_match.sv
module sim_blk_xlate_match;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_side = 1'b0, wr_hi = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0, req_user = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_perm;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_up [2][4];
  logic [31:0] m_lo [2][4];

  always #5 clk = ~clk;

  blk_xlate_match u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side),
    .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_data(wr_data),
    .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind),
    .req_user(req_user), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .rsp_perm(rsp_perm)
  );

  function automatic logic [2:0] ref_rights(input logic [1:0] c);
    if (c == 2'd0) return 3'b000;
    if (c == 2'd2) return 3'b111;
    return 3'b101;
  endfunction

  function automatic bit ref_match(input logic [31:0] up, input logic [31:0] ea);
    if (ea[31:28] != up[31:28]) return 0;
    for (int k = 17; k <= 27; k++) begin
      if (up[k-15]) begin
        if (up[k]) return 0;
      end else if (ea[k] != up[k]) return 0;
    end
    return 1;
  endfunction

  function automatic void ref_eval(input logic [1:0] kind, input logic user,
                                   input logic [31:0] ea,
                                   output logic [2:0] flags, output logic [31:0] pa,
                                   output logic [2:0] pr);
    int s;
    s = kind[1] ? 1 : 0;
    flags = 3'b010; pa = 0; pr = 0;
    for (int e = 0; e < 4; e++) begin
      logic [31:0] up, lo;
      bit ok;
      up = m_up[s][e]; lo = m_lo[s][e];
      if (ref_match(up, ea) && (user ? up[0] : up[1])) begin
        pr = ref_rights(lo[1:0]);
        pa[16:0] = ea[16:0];
        pa[31:28] = lo[31:28];
        for (int k = 17; k <= 27; k++) pa[k] = lo[k] | (ea[k] & up[k-15]);
        ok = kind[1] ? pr[0] : (kind[0] ? pr[1] : pr[2]);
        flags = ok ? 3'b100 : 3'b001;
        return;
      end
    end
  endfunction

  task automatic check(input string req, input logic [2:0] ef,
                       input logic [31:0] epa, input logic [2:0] epr);
    n_chk++;
    if (!(rsp_valid === 1'b1 && {rsp_hit, rsp_miss, rsp_fault} === ef &&
          rsp_pa === epa && rsp_perm === epr)) begin
      n_bad++;
      $display("FAIL %s: got v=%b hmf=%b pa=%h perm=%b exp v=1 hmf=%b pa=%h perm=%b",
               req, rsp_valid, {rsp_hit, rsp_miss, rsp_fault}, rsp_pa, rsp_perm,
               ef, epa, epr);
    end
  endtask

  task automatic wr(input bit side, input int idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_side = side; wr_idx = 2'(idx); wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (hi) m_up[side][idx] = d; else m_lo[side][idx] = d;
  endtask

  task automatic rq(input string req, input logic [1:0] kind, input logic user,
                    input logic [31:0] ea);
    logic [2:0] f, pr; logic [31:0] pa;
    ref_eval(kind, user, ea, f, pa, pr);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_user = user; req_ea = ea;
    @(negedge clk);
    req_valid = 0;
    check(req, f, pa, pr);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 4; e++) begin m_up[s][e] = 0; m_lo[s][e] = 0; end
    repeat (3) @(negedge clk);
    // R1: idle outputs zero in reset
    n_chk++;
    if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pa, rsp_perm} !== '0) begin
      n_bad++; $display("FAIL R1: got nonzero outputs in reset exp zero");
    end
    rst_n = 1;
    rq("R1 empty data", 2'b00, 0, 32'h0000_0000);
    rq("R1 empty fetch", 2'b10, 1, 32'h1234_5678);
    // R2: no response in the following idle cycle
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0 || rsp_fault !== 0) begin
      n_bad++; $display("FAIL R2: got v=%b exp 0 in idle cycle", rsp_valid);
    end
    // R6 R7: supervisor-only data mapping, all rights
    wr(0, 0, 1, 32'h3000_0002);
    wr(0, 0, 0, 32'h8000_0002);
    rq("R6 R7 load", 2'b00, 0, 32'h3001_1234);
    rq("R4 user skipped", 2'b00, 1, 32'h3001_1234);
    rq("R3 fetch uses instr set", 2'b10, 0, 32'h3001_1234);
    wr(1, 0, 1, 32'h3000_0001);
    wr(1, 0, 0, 32'h4000_0003);
    rq("R3 R7 fetch hit", 2'b10, 1, 32'h3000_0abc);
    // R5 R6: full-length mask, read/execute only, store faults
    wr(0, 1, 1, 32'h5000_1FFF);
    wr(0, 1, 0, 32'h9000_0001);
    rq("R5 R6 full mask load", 2'b00, 1, 32'h5ABC_DEF0);
    rq("R9 store fault", 2'b01, 0, 32'h5FFE_0000);
    // R5: stored bit under set mask bit never matches
    wr(0, 2, 1, 32'h6002_0006);
    rq("R5 masked stored bit", 2'b00, 0, 32'h6002_0000);
    rq("R5 masked stored bit b", 2'b00, 0, 32'h6000_0000);
    // R8: priority and skipping of not-live entries
    wr(0, 2, 1, 32'h7000_0002);
    wr(0, 2, 0, 32'hA000_0002);
    wr(0, 3, 1, 32'h7000_0003);
    wr(0, 3, 0, 32'hB000_0001);
    rq("R8 sup picks lower index", 2'b01, 0, 32'h7000_0010);
    rq("R8 user skips entry", 2'b01, 1, 32'h7000_0010);
    // R7 R9: no rights faults load
    wr(0, 3, 0, 32'hB000_0000);
    rq("R7 R9 none fault", 2'b00, 1, 32'h7000_0010);
    // R11: request in same cycle as write sees old contents
    begin
      logic [2:0] f, pr; logic [31:0] pa;
      ref_eval(2'b00, 1, 32'h7000_0020, f, pa, pr);
      @(negedge clk);
      wr_en = 1; wr_side = 0; wr_idx = 2'd3; wr_hi = 0; wr_data = 32'hC000_0002;
      req_valid = 1; req_kind = 2'b00; req_user = 1; req_ea = 32'h7000_0020;
      @(negedge clk);
      wr_en = 0; req_valid = 0;
      check("R11 same-cycle old view", f, pa, pr);
      m_lo[0][3] = 32'hC000_0002;
    end
    rq("R11 next-cycle new view", 2'b00, 1, 32'h7000_0020);
    // random mix
    for (int it = 0; it < 60; it++) begin
      bit side; int idx; logic [31:0] up, lo;
      side = 1'($urandom); idx = int'($urandom % 4);
      up = {4'($urandom % 4), 11'($urandom), 4'h0, 11'($urandom), 2'($urandom)};
      if ($urandom % 4 != 0) up[27:17] = up[27:17] & ~up[12:2];
      lo = $urandom;
      wr(side, idx, 1, up);
      wr(side, idx, 0, lo);
      for (int j = 0; j < 6; j++) begin
        logic [31:0] ea; int s2, e2;
        s2 = int'($urandom % 2); e2 = int'($urandom % 4);
        ea = $urandom;
        ea[31:28] = m_up[s2][e2][31:28];
        if ($urandom % 2) ea[27:17] = m_up[s2][e2][27:17] | (11'($urandom) & m_up[s2][e2][12:2]);
        rq("R5 R6 R8 R9 random", {s2[0], 1'($urandom)}, 1'($urandom), ea);
      end
    end
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule